// File: doc/BRIEF.md
# Scaled-Index Word Load Unit

This block is the data-memory load path for one 32-bit load operation in a processor pipeline. An issued operation carries a base value, an index value, a guard value, a byte-order select and a destination tag. The unit forms the effective address as base plus four times the index and fetches the aligned 32-bit word holding it from a synchronous read port. It then arranges the four bytes into a 32-bit result in big-endian or little-endian order. The result returns with a destination write enable and the tag exactly three cycles after issue. A new operation may be issued every cycle.

The guard cancels the whole operation when its least significant bit is 0. No memory request is made, the write enable stays low and no cache-status strobe is raised. Addresses inside a parameterised memory-mapped I/O window always return the bus word as it arrives, whatever the byte-order select says. These addresses are treated as non-cacheable. Misaligned effective addresses produce an unspecified result value. They raise no fault, and the write enable behaves as for any other guarded operation.

The read port presents the byte at word address + k on bus lane k, which is bits 8k+7 down to 8k.

Top module: `scaled_word_load`

## Requirements
- R1: The effective address is iss_base + 4 × iss_index, computed modulo 2^32. One cycle after issue, mem_addr carries that address with bits 1:0 cleared (for example base 0xd0c with index 0xfffffffe reads word 0xd04).
- R2: With iss_order = 0 (big-endian) outside the I/O window, wb_data[31:24] is bus lane 0, [23:16] is lane 1, [15:8] is lane 2 and [7:0] is lane 3. Bytes 0x84, 0x33, 0x22, 0x11 at 0xd00..0xd03 yield 0x84332211.
- R3: With iss_order = 1 (little-endian) outside the I/O window, wb_data[8k+7:8k] is bus lane k, for k = 0..3.
- R4: Only iss_guard[0] is examined. When it is 0, mem_req stays low in the following cycle, and wb_en and cache_touch stay low when the result would be due. The other guard bits have no effect.
- R5: An operation issued with iss_valid = 1 and guard bit 0 = 1 raises wb_en, with wb_tag equal to its iss_tag, exactly 3 cycles after issue. Back-to-back issues each return in order with no gap.
- R6: When the effective address lies in [IO_BASE, IO_BASE + IO_SIZE), wb_data equals the bus word unchanged for either value of iss_order, and cache_touch stays low.
- R7: cache_touch rises together with wb_en for a guarded operation whose effective address lies outside the I/O window.
- R8: A misaligned effective address raises no error. wb_en and cache_touch follow R5 and R7, and the value of wb_data is unspecified.
- R9: While rst_n is low, mem_req, wb_en, cache_touch and wb_data are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | An operation is issued this cycle |
| iss_base | input | 32 | Base register value |
| iss_index | input | 32 | Index register value, scaled by four |
| iss_guard | input | 32 | Guard register value; only bit 0 is used |
| iss_order | input | 1 | Byte order: 0 big-endian, 1 little-endian |
| iss_tag | input | TAG_W | Destination register tag |
| mem_req | output | 1 | Read request to data memory |
| mem_addr | output | 32 | Word-aligned read address |
| mem_rdata | input | 32 | Read word, valid one cycle after mem_req |
| wb_en | output | 1 | Destination register write enable |
| wb_tag | output | TAG_W | Destination register tag of the result |
| wb_data | output | 32 | Load result |
| cache_touch | output | 1 | Cache-status update strobe |

## Verification
The bench builds the unit with TAG_W = 5 and moves the I/O window down to IO_BASE = 0x8000 with IO_SIZE = 0x1000. Randomly drawn bases below 0x10000 therefore land inside the window often enough to exercise pass-through in both byte orders. Directed cases also reach both edges of the window, 0x7FFC, 0x8000, 0x8FFC and 0x9000. The five-bit tag field makes reordering or a lost slot visible across long back-to-back streams, and negative indices exercise address wrap-around.

// File: rtl/ldx_pkg.sv
package ldx_pkg;

    localparam int unsigned WORD_W  = 32;
    localparam int unsigned BYTES   = WORD_W / 8;
    localparam int unsigned SCALE_SH = 2;

    typedef enum logic {
        ORD_BIG    = 1'b0,
        ORD_LITTLE = 1'b1
    } byte_order_e;

    typedef enum logic {
        LANE_SWAP = 1'b0,
        LANE_PASS = 1'b1
    } lane_mode_e;

    typedef struct packed {
        logic       live;
        logic       wr;
        logic       io;
        lane_mode_e mode;
    } stage_ctl_t;

endpackage

// File: rtl/ldx_pipe_reg.sv
module ldx_pipe_reg #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/ldx_agen.sv
module ldx_agen
    import ldx_pkg::*;
#(
    parameter int unsigned      ADDR_W  = 32,
    parameter logic [ADDR_W-1:0] IO_BASE = '0,
    parameter logic [ADDR_W-1:0] IO_SIZE = '0
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  byte_order_e       order,
    output logic [ADDR_W-1:0] word_addr,
    output logic              in_io,
    output lane_mode_e        mode
);

    localparam int unsigned OFS_W = $clog2(BYTES);

    logic [ADDR_W-1:0] eff_addr;
    logic [ADDR_W-1:0] io_rel;

    always_comb begin
        eff_addr  = base + (index << SCALE_SH);
        word_addr = {eff_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
        io_rel    = eff_addr - IO_BASE;
        in_io     = (io_rel < IO_SIZE);
    end

    always_comb begin
        unique case (order)
            ORD_BIG:    mode = in_io ? LANE_PASS : LANE_SWAP;
            ORD_LITTLE: mode = LANE_PASS;
            default:    mode = LANE_PASS;
        endcase
    end

endmodule

// File: rtl/ldx_lane_merge.sv
module ldx_lane_merge
    import ldx_pkg::*;
(
    input  lane_mode_e        mode,
    input  logic [WORD_W-1:0] bus_word,
    output logic [WORD_W-1:0] result
);

    logic [WORD_W-1:0] swapped;

    for (genvar k = 0; k < BYTES; k++) begin : g_lane
        assign swapped[8*k +: 8] = bus_word[8*(BYTES-1-k) +: 8];
    end

    always_comb begin
        unique case (mode)
            LANE_SWAP: result = swapped;
            LANE_PASS: result = bus_word;
            default:   result = bus_word;
        endcase
    end

endmodule

// File: rtl/scaled_word_load.sv
module scaled_word_load
    import ldx_pkg::*;
#(
    parameter int unsigned ADDR_W  = 32,
    parameter int unsigned TAG_W   = 5,
    parameter logic [31:0] IO_BASE = 32'hF000_0000,
    parameter logic [31:0] IO_SIZE = 32'h0010_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [31:0]      iss_base,
    input  logic [31:0]      iss_index,
    input  logic [31:0]      iss_guard,
    input  logic             iss_order,
    input  logic [TAG_W-1:0] iss_tag,
    output logic             mem_req,
    output logic [31:0]      mem_addr,
    input  logic [31:0]      mem_rdata,
    output logic             wb_en,
    output logic [TAG_W-1:0] wb_tag,
    output logic [31:0]      wb_data,
    output logic             cache_touch
);

    localparam int unsigned CTL_W = $bits(stage_ctl_t);

    // stage 0: address generation and window decode
    logic [31:0] word_addr;
    logic        in_io;
    lane_mode_e  mode0;
    stage_ctl_t  s1_d;
    stage_ctl_t  s1_q;
    stage_ctl_t  s2_q;
    logic [31:0] s1_addr;
    logic [TAG_W-1:0] s1_tag;
    logic [TAG_W-1:0] s2_tag;
    logic [31:0] merged;
    logic        take;

    assign take = iss_valid & iss_guard[0];

    ldx_agen #(
        .ADDR_W (32),
        .IO_BASE(IO_BASE),
        .IO_SIZE(IO_SIZE)
    ) u_agen (
        .base     (iss_base),
        .index    (iss_index),
        .order    (byte_order_e'(iss_order)),
        .word_addr(word_addr),
        .in_io    (in_io),
        .mode     (mode0)
    );

    always_comb begin
        s1_d.live = iss_valid;
        s1_d.wr   = take;
        s1_d.io   = in_io;
        s1_d.mode = mode0;
    end

    // stage 1: request to memory
    ldx_pipe_reg #(.W(CTL_W)) u_s1_ctl (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(s1_d), .q(s1_q)
    );

    ldx_pipe_reg #(.W(32)) u_s1_addr (
        .clk(clk), .rst_n(rst_n), .en(take), .d(word_addr), .q(s1_addr)
    );

    ldx_pipe_reg #(.W(TAG_W)) u_s1_tag (
        .clk(clk), .rst_n(rst_n), .en(iss_valid), .d(iss_tag), .q(s1_tag)
    );

    assign mem_req  = s1_q.wr;
    assign mem_addr = s1_addr;

    // stage 2: memory word arrives
    ldx_pipe_reg #(.W(CTL_W)) u_s2_ctl (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(s1_q), .q(s2_q)
    );

    ldx_pipe_reg #(.W(TAG_W)) u_s2_tag (
        .clk(clk), .rst_n(rst_n), .en(s1_q.live), .d(s1_tag), .q(s2_tag)
    );

    ldx_lane_merge u_merge (
        .mode    (s2_q.mode),
        .bus_word(mem_rdata),
        .result  (merged)
    );

    // stage 3: write-back
    ldx_pipe_reg #(.W(1)) u_s3_wb (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(s2_q.wr), .q(wb_en)
    );

    ldx_pipe_reg #(.W(1)) u_s3_cache (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .d(s2_q.wr & ~s2_q.io), .q(cache_touch)
    );

    ldx_pipe_reg #(.W(32)) u_s3_data (
        .clk(clk), .rst_n(rst_n), .en(s2_q.wr), .d(merged), .q(wb_data)
    );

    ldx_pipe_reg #(.W(TAG_W)) u_s3_tag (
        .clk(clk), .rst_n(rst_n), .en(s2_q.live), .d(s2_tag), .q(wb_tag)
    );

endmodule

// File: rtl/ldx_load_checker.sv
module ldx_load_checker #(
    parameter int unsigned TAG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iss_valid,
    input logic [31:0]      iss_base,
    input logic [31:0]      iss_index,
    input logic [31:0]      iss_guard,
    input logic [TAG_W-1:0] iss_tag,
    input logic             mem_req,
    input logic [31:0]      mem_addr,
    input logic             wb_en,
    input logic [TAG_W-1:0] wb_tag,
    input logic             cache_touch
);

    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age <= 2'd0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R1

    AST_ADDR_SCALED: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && mem_req) |->
        (mem_addr == (($past(iss_base) + ($past(iss_index) << 2)) & 32'hFFFF_FFFC))); // R1

    AST_REQ_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0) |-> (mem_req == $past(iss_valid && iss_guard[0]))); // R4

    AST_WB_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3) |-> (wb_en == $past(iss_valid && iss_guard[0], 3))); // R5

    AST_TAG_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && wb_en) |-> (wb_tag == $past(iss_tag, 3))); // R5

    AST_CACHE_WITH_WB: assert property (@(posedge clk) disable iff (!rst_n)
        cache_touch |-> wb_en); // R7

endmodule

bind scaled_word_load ldx_load_checker #(.TAG_W(TAG_W)) u_ldx_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .iss_valid  (iss_valid),
    .iss_base   (iss_base),
    .iss_index  (iss_index),
    .iss_guard  (iss_guard),
    .iss_tag    (iss_tag),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .wb_en      (wb_en),
    .wb_tag     (wb_tag),
    .cache_touch(cache_touch)
);

// File: tb/tb_scaled_word_load.sv
`timescale 1ns/1ps
module tb_scaled_word_load;

    localparam int unsigned TAG_W   = 5;
    localparam logic [31:0] IO_BASE = 32'h0000_8000;
    localparam logic [31:0] IO_SIZE = 32'h0000_1000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             iss_valid = 1'b0;
    logic [31:0]      iss_base = '0;
    logic [31:0]      iss_index = '0;
    logic [31:0]      iss_guard = '0;
    logic             iss_order = 1'b0;
    logic [TAG_W-1:0] iss_tag = '0;
    logic             mem_req;
    logic [31:0]      mem_addr;
    logic [31:0]      mem_rdata = '0;
    logic             wb_en;
    logic [TAG_W-1:0] wb_tag;
    logic [31:0]      wb_data;
    logic             cache_touch;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scaled_word_load #(
        .TAG_W(TAG_W), .IO_BASE(IO_BASE), .IO_SIZE(IO_SIZE)
    ) dut (
        .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_base(iss_base),
        .iss_index(iss_index), .iss_guard(iss_guard), .iss_order(iss_order),
        .iss_tag(iss_tag), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .wb_en(wb_en), .wb_tag(wb_tag),
        .wb_data(wb_data), .cache_touch(cache_touch)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] wa);
        if (wa == 32'h0000_0d00) return 32'h1122_3384;
        if (wa == 32'h0000_0d04) return 32'h4455_6648;
        return (wa * 32'h9E37_79B1) ^ 32'hA5C3_0F17;
    endfunction

    function automatic logic [31:0] bswap(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    always @(posedge clk) begin
        if (mem_req) mem_rdata <= mem_word(mem_addr);
    end

    // expected slots: index 0 = issued one step ago, 2 = due now
    logic        p_req  [3];
    logic [31:0] p_addr [3];
    logic        p_wb   [3];
    logic        p_cache[3];
    logic        p_cmp  [3];
    logic [31:0] p_data [3];
    logic [TAG_W-1:0] p_tag[3];
    string       p_drq  [3];
    string       p_wrq  [3];

    task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=0x%08h exp=0x%08h t=%0t", rq, act, exp, $time);
        end
    endtask

    task automatic step(input bit v, input logic [31:0] b, input logic [31:0] ix,
                        input logic [31:0] g, input bit ord, input logic [TAG_W-1:0] tg);
        logic [31:0] ea;
        logic        io;
        logic [31:0] w;
        chk(mem_req == p_req[0], "R4", {31'd0, mem_req}, {31'd0, p_req[0]});
        if (p_req[0]) chk(mem_addr == p_addr[0], "R1", mem_addr, p_addr[0]);
        chk(wb_en == p_wb[2], p_wrq[2], {31'd0, wb_en}, {31'd0, p_wb[2]});
        chk(cache_touch == p_cache[2], "R7", {31'd0, cache_touch}, {31'd0, p_cache[2]});
        if (p_wb[2]) chk(wb_tag == p_tag[2], "R5", {27'd0, wb_tag}, {27'd0, p_tag[2]});
        if (p_cmp[2]) chk(wb_data == p_data[2], p_drq[2], wb_data, p_data[2]);
        for (int i = 2; i > 0; i--) begin
            p_req[i] = p_req[i-1];   p_addr[i] = p_addr[i-1];
            p_wb[i] = p_wb[i-1];     p_cache[i] = p_cache[i-1];
            p_cmp[i] = p_cmp[i-1];   p_data[i] = p_data[i-1];
            p_tag[i] = p_tag[i-1];   p_drq[i] = p_drq[i-1];
            p_wrq[i] = p_wrq[i-1];
        end
        ea = b + (ix << 2);
        io = ((ea - IO_BASE) < IO_SIZE);
        w  = mem_word({ea[31:2], 2'b00});
        p_req[0]   = v && g[0];
        p_addr[0]  = {ea[31:2], 2'b00};
        p_wb[0]    = v && g[0];
        p_cache[0] = v && g[0] && !io;
        p_cmp[0]   = v && g[0] && (ea[1:0] == 2'b00);
        p_data[0]  = (io || ord) ? w : bswap(w);
        p_tag[0]   = tg;
        p_drq[0]   = io ? "R6" : (ord ? "R3" : "R2");
        p_wrq[0]   = (ea[1:0] != 2'b00) ? "R8" : (g[0] ? "R5" : "R4");
        iss_valid = v; iss_base = b; iss_index = ix;
        iss_guard = g; iss_order = ord; iss_tag = tg;
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, '0, 1'b0, '0);
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            p_req[i] = 0; p_addr[i] = '0; p_wb[i] = 0; p_cache[i] = 0;
            p_cmp[i] = 0; p_data[i] = '0; p_tag[i] = '0;
            p_drq[i] = "R2"; p_wrq[i] = "R9";
        end
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(mem_req == 1'b0, "R9", {31'd0, mem_req}, 32'd0);
        chk(wb_en == 1'b0, "R9", {31'd0, wb_en}, 32'd0);
        chk(cache_touch == 1'b0, "R9", {31'd0, cache_touch}, 32'd0);
        chk(wb_data == 32'd0, "R9", wb_data, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: big-endian word at 0xd00 via base 0xcfc + 4*1
        step(1'b1, 32'h0000_0cfc, 32'h1, 32'h1, 1'b0, 5'd1);
        // R4: guard bit 0 clear, upper bits set
        step(1'b1, 32'h0000_0d0c, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 1'b0, 5'd2);
        // R1: wrap-around index, result 0x48665544
        step(1'b1, 32'h0000_0d0c, 32'hFFFF_FFFE, 32'h1, 1'b0, 5'd3);
        // R3: little-endian of the same word at 0xd00
        step(1'b1, 32'h0000_0d00, 32'h0, 32'h3, 1'b1, 5'd4);
        // R8: misaligned 0xd01 + 4
        step(1'b1, 32'h0000_0d01, 32'h1, 32'h1, 1'b0, 5'd5);
        // R6: window edges, big-endian select
        step(1'b1, 32'h0000_7FFC, 32'h0, 32'h1, 1'b0, 5'd6);
        step(1'b1, 32'h0000_8000, 32'h0, 32'h1, 1'b0, 5'd7);
        step(1'b1, 32'h0000_8FF8, 32'h1, 32'h1, 1'b0, 5'd8);
        step(1'b1, 32'h0000_9000, 32'h0, 32'h1, 1'b0, 5'd9);
        step(1'b1, 32'h0000_8400, 32'h0, 32'h1, 1'b1, 5'd10);
        idle(4);

        for (int n = 0; n < 600; n++) begin
            logic [31:0] b;
            logic [31:0] ix;
            b  = {16'd0, 16'($urandom_range(0, 16'hFFFF))};
            if ($urandom_range(0, 7) != 0) b[1:0] = 2'b00;
            if ($urandom_range(0, 9) == 0) b = $urandom();
            ix = 32'($signed($urandom_range(0, 256)) - 128);
            if ($urandom_range(0, 9) == 0) ix = $urandom();
            step($urandom_range(0, 9) != 0, b, ix, $urandom(),
                 1'($urandom_range(0, 1)), TAG_W'($urandom()));
        end
        idle(4);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R5 act=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule